// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block tracks how error-prone a CAN node has been. It keeps two saturating counters, one for transmit-side faults and one for receive-side faults. The bit stream processor drives single-cycle command pulses that raise or lower them. A weight input turns an increment into a step of eight instead of one. The counter values that result place the node in one of three confinement states: error-active, error-passive or bus-off. The rest of the controller reads these states through two flags.

Events reach the block already classified. The block does not decide which fault happened; it only applies the command it receives. Once the node is bus-off, counter commands stop having any effect. The node then waits for a pulse that marks each run of eleven consecutive recessive bits on the bus. After enough of these pulses, both counters clear and the node goes back to error-active.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous active-high reset clears both counters to 0 and drives errPassive and busOff low.
- R2: A txErrInc pulse raises the transmit counter by 1, or by 8 when txStep8 is high in the same cycle. The new value is visible after the next rising edge, and the receive counter does not change.
- R3: A rxErrInc pulse raises the receive counter by 1, or by 8 when rxStep8 is high in the same cycle. The 8-bit receive counter saturates at 255.
- R4: A decrement pulse lowers its counter by 1. A counter that is at 0 stays at 0.
- R5: When increment and decrement pulses for the same counter arrive in the same cycle, only the increment is applied.
- R6: While not bus-off, errPassive is high whenever either counter is 128 or more.
- R7: errPassive returns low only when both counters are 127 or less.
- R8: The node enters bus-off when the 9-bit transmit counter reaches 256 or more. While bus-off, busOff is high and errPassive is low.
- R9: While bus-off, all increment and decrement commands are ignored, and both counters hold their values.
- R10: While bus-off, the 128th idleSeen pulse clears both counters to 0 and returns the node to error-active, with both flags low. idleSeen pulses received outside bus-off do not count towards recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txErrInc | input | 1 | Raise transmit counter |
| txStep8 | input | 1 | Transmit increment weight: 1 selects 8, 0 selects 1 |
| txErrDec | input | 1 | Lower transmit counter by 1 |
| rxErrInc | input | 1 | Raise receive counter |
| rxStep8 | input | 1 | Receive increment weight: 1 selects 8, 0 selects 1 |
| rxErrDec | input | 1 | Lower receive counter by 1 |
| idleSeen | input | 1 | One pulse per detected run of 11 recessive bits |
| txErrCount | output | 9 | Transmit error counter |
| rxErrCount | output | 8 | Receive error counter |
| errPassive | output | 1 | Node is error-passive |
| busOff | output | 1 | Node is bus-off |

## Verification
The hardest case to reach from the ports is recovery from bus-off. The node first needs 32 weighted transmit increments to get there, and then it needs exactly 128 idle pulses to leave. Before driving the node into bus-off, the bench sends a batch of idle pulses while the node is error-active. It also loads the receive counter with a nonzero value. Once the node is bus-off, the bench checks that the flag is still high after 127 pulses and that it drops on the 128th. This shows that the earlier pulses were not counted and that the held receive value is cleared on exit.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } nodeState_t;

  typedef struct packed {
    logic txUp;
    logic txBig;
    logic txDown;
    logic rxUp;
    logic rxBig;
    logic rxDown;
    logic clearAll;
  } cntStrobe_t;

endpackage

// File: rtl/fc_satcnt.sv
module fc_satcnt #(
  parameter int W   = 8,
  parameter int BIG = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         up,
  input  logic         big,
  input  logic         down,
  output logic [W-1:0] value,
  output logic [W-1:0] nextValue
);

  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] BIGV = W'(BIG);
  localparam logic [W-1:0] ONEV = W'(1);

  logic [W-1:0] step;

  always_comb begin
    step = big ? BIGV : ONEV;
    if (clr)
      nextValue = '0;
    else if (up)
      nextValue = (value > (MAXV - step)) ? MAXV : (value + step);
    else if (down)
      nextValue = (value == '0) ? '0 : (value - ONEV);
    else
      nextValue = value;
  end

  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else     value <= nextValue;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (value == '0 && down && !up && !clr) |=> (value == '0)); // R4

  AST_INC_WINS: assert property (@(posedge clk) disable iff (rst)
    (up && down && !clr && value != MAXV) |=> (value > $past(value))); // R5

endmodule

// File: rtl/fc_counters.sv
module fc_counters
  import fc_pkg::*;
#(
  parameter int TX_W = 9,
  parameter int RX_W = 8,
  parameter int BIG  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  cntStrobe_t      strobe,
  output logic [TX_W-1:0] txCount,
  output logic [RX_W-1:0] rxCount,
  output logic [TX_W-1:0] txNext,
  output logic [RX_W-1:0] rxNext
);

  fc_satcnt #(.W(TX_W), .BIG(BIG)) txCnt (
    .clk(clk), .rst(rst), .clr(strobe.clearAll),
    .up(strobe.txUp), .big(strobe.txBig), .down(strobe.txDown),
    .value(txCount), .nextValue(txNext)
  );

  fc_satcnt #(.W(RX_W), .BIG(BIG)) rxCnt (
    .clk(clk), .rst(rst), .clr(strobe.clearAll),
    .up(strobe.rxUp), .big(strobe.rxBig), .down(strobe.rxDown),
    .value(rxCount), .nextValue(rxNext)
  );

endmodule

// File: rtl/fc_control.sv
module fc_control
  import fc_pkg::*;
#(
  parameter int TX_W          = 9,
  parameter int RX_W          = 8,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 256,
  parameter int RECOVER_COUNT = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            txErrInc,
  input  logic            txStep8,
  input  logic            txErrDec,
  input  logic            rxErrInc,
  input  logic            rxStep8,
  input  logic            rxErrDec,
  input  logic            idleSeen,
  input  logic [TX_W-1:0] txNext,
  input  logic [RX_W-1:0] rxNext,
  output cntStrobe_t      strobe,
  output logic            errPassive,
  output logic            busOff
);

  localparam int RCW = $clog2(RECOVER_COUNT + 1);
  localparam logic [TX_W-1:0] TX_PASS = TX_W'(PASSIVE_LIMIT);
  localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASSIVE_LIMIT);
  localparam logic [TX_W-1:0] TX_OFF  = TX_W'(BUSOFF_LIMIT);
  localparam logic [RCW-1:0]  REC_LAST = RCW'(RECOVER_COUNT - 1);

  nodeState_t stateQ, stateD;
  logic [RCW-1:0] recoverCnt;
  logic inBusOff, live, recoverDone;

  assign inBusOff    = (stateQ == ST_BUSOFF);
  assign live        = !inBusOff;
  assign recoverDone = inBusOff && idleSeen && (recoverCnt == REC_LAST);

  always_comb begin
    strobe.txUp     = live && txErrInc;
    strobe.txBig    = txStep8;
    strobe.txDown   = live && txErrDec && !txErrInc;
    strobe.rxUp     = live && rxErrInc;
    strobe.rxBig    = rxStep8;
    strobe.rxDown   = live && rxErrDec && !rxErrInc;
    strobe.clearAll = recoverDone;
  end

  always_comb begin
    if (inBusOff)
      stateD = recoverDone ? ST_ACTIVE : ST_BUSOFF;
    else if (txNext >= TX_OFF)
      stateD = ST_BUSOFF;
    else if (txNext >= TX_PASS || rxNext >= RX_PASS)
      stateD = ST_PASSIVE;
    else
      stateD = ST_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_ACTIVE;
    else     stateQ <= stateD;
  end

  always_ff @(posedge clk) begin
    if (rst || !inBusOff)
      recoverCnt <= '0;
    else if (idleSeen)
      recoverCnt <= recoverDone ? '0 : (recoverCnt + RCW'(1));
  end

  assign errPassive = (stateQ == ST_PASSIVE);
  assign busOff     = inBusOff;

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(errPassive && busOff)); // R8

  AST_RECOVER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inBusOff) |=> (recoverCnt == '0)); // R10

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import fc_pkg::*;
#(
  parameter int TX_W          = 9,
  parameter int RX_W          = 8,
  parameter int BIG_STEP      = 8,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 256,
  parameter int RECOVER_COUNT = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            txErrInc,
  input  logic            txStep8,
  input  logic            txErrDec,
  input  logic            rxErrInc,
  input  logic            rxStep8,
  input  logic            rxErrDec,
  input  logic            idleSeen,
  output logic [TX_W-1:0] txErrCount,
  output logic [RX_W-1:0] rxErrCount,
  output logic            errPassive,
  output logic            busOff
);

  cntStrobe_t strobe;
  logic [TX_W-1:0] txNext;
  logic [RX_W-1:0] rxNext;

  fc_control #(
    .TX_W(TX_W), .RX_W(RX_W), .PASSIVE_LIMIT(PASSIVE_LIMIT),
    .BUSOFF_LIMIT(BUSOFF_LIMIT), .RECOVER_COUNT(RECOVER_COUNT)
  ) ctrl (
    .clk(clk), .rst(rst),
    .txErrInc(txErrInc), .txStep8(txStep8), .txErrDec(txErrDec),
    .rxErrInc(rxErrInc), .rxStep8(rxStep8), .rxErrDec(rxErrDec),
    .idleSeen(idleSeen), .txNext(txNext), .rxNext(rxNext),
    .strobe(strobe), .errPassive(errPassive), .busOff(busOff)
  );

  fc_counters #(.TX_W(TX_W), .RX_W(RX_W), .BIG(BIG_STEP)) dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .txCount(txErrCount), .rxCount(rxErrCount),
    .txNext(txNext), .rxNext(rxNext)
  );

  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (txErrCount >= TX_W'(BUSOFF_LIMIT)) |-> busOff); // R8

  AST_PASSIVE_SET: assert property (@(posedge clk) disable iff (rst)
    (!busOff && (txErrCount >= TX_W'(PASSIVE_LIMIT) ||
                 rxErrCount >= RX_W'(PASSIVE_LIMIT))) |-> errPassive); // R6

  AST_ACTIVE_RETURN: assert property (@(posedge clk) disable iff (rst)
    (txErrCount < TX_W'(PASSIVE_LIMIT) &&
     rxErrCount < RX_W'(PASSIVE_LIMIT)) |-> !errPassive); // R7

  AST_COUNTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busOff && $past(busOff)) |-> ($stable(txErrCount) && $stable(rxErrCount))); // R9

  AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(busOff) |-> (txErrCount == '0 && rxErrCount == '0)); // R10

endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txErrInc = 0, txStep8 = 0, txErrDec = 0;
  logic rxErrInc = 0, rxStep8 = 0, rxErrDec = 0;
  logic idleSeen = 0;
  logic [8:0] txErrCount;
  logic [7:0] rxErrCount;
  logic errPassive, busOff;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  can_fault_conf uut (
    .clk(clk), .rst(rst),
    .txErrInc(txErrInc), .txStep8(txStep8), .txErrDec(txErrDec),
    .rxErrInc(rxErrInc), .rxStep8(rxStep8), .rxErrDec(rxErrDec),
    .idleSeen(idleSeen),
    .txErrCount(txErrCount), .rxErrCount(rxErrCount),
    .errPassive(errPassive), .busOff(busOff)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkAll(input string req, input int tx, input int rx,
                        input int ep, input int bo);
    chk({req, " tx"}, int'(txErrCount), tx);
    chk({req, " rx"}, int'(rxErrCount), rx);
    chk({req, " errPassive"}, int'(errPassive), ep);
    chk({req, " busOff"}, int'(busOff), bo);
  endtask

  // one command cycle; outputs sampled at the following falling edge
  task automatic cmd(input bit ti, input bit tb, input bit td,
                     input bit ri, input bit rb, input bit rd, input bit id);
    @(negedge clk);
    txErrInc = ti; txStep8 = tb; txErrDec = td;
    rxErrInc = ri; rxStep8 = rb; rxErrDec = rd; idleSeen = id;
    @(negedge clk);
    txErrInc = 0; txStep8 = 0; txErrDec = 0;
    rxErrInc = 0; rxStep8 = 0; rxErrDec = 0; idleSeen = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic testReset();
    doReset();
    chkAll("R1 reset", 0, 0, 0, 0);
    cmd(1, 1, 0, 1, 1, 0, 0);
    doReset();
    chkAll("R1 reset after load", 0, 0, 0, 0);
  endtask

  task automatic testTxSteps();
    doReset();
    cmd(1, 0, 0, 0, 0, 0, 0);
    chkAll("R2 tx +1", 1, 0, 0, 0);
    cmd(1, 1, 0, 0, 0, 0, 0);
    chkAll("R2 tx +8", 9, 0, 0, 0);
    cmd(0, 0, 1, 0, 0, 0, 0);
    chk("R4 tx dec", int'(txErrCount), 8);
    for (int i = 0; i < 8; i++) cmd(0, 0, 1, 0, 0, 0, 0);
    chk("R4 tx to zero", int'(txErrCount), 0);
    cmd(0, 0, 1, 0, 0, 0, 0);
    chk("R4 tx floor", int'(txErrCount), 0);
  endtask

  task automatic testRxSteps();
    doReset();
    cmd(0, 0, 0, 1, 1, 0, 0);
    chkAll("R3 rx +8", 0, 8, 0, 0);
    cmd(0, 0, 0, 1, 0, 0, 0);
    chk("R3 rx +1", int'(rxErrCount), 9);
    cmd(0, 0, 0, 1, 0, 1, 0);
    chk("R5 rx inc beats dec", int'(rxErrCount), 10);
    cmd(1, 1, 1, 0, 0, 0, 0);
    chk("R5 tx inc beats dec", int'(txErrCount), 8);
    cmd(0, 0, 0, 0, 0, 1, 0);
    chk("R4 rx dec", int'(rxErrCount), 9);
    for (int i = 0; i < 10; i++) cmd(0, 0, 0, 0, 0, 1, 0);
    chk("R4 rx floor", int'(rxErrCount), 0);
  endtask

  task automatic testPassive();
    doReset();
    for (int i = 0; i < 15; i++) cmd(0, 0, 0, 1, 1, 0, 0);
    chkAll("R6 rx 120 still active", 0, 120, 0, 0);
    cmd(0, 0, 0, 1, 1, 0, 0);
    chkAll("R6 rx 128 passive", 0, 128, 1, 0);
    for (int i = 0; i < 16; i++) cmd(1, 1, 0, 0, 0, 0, 0);
    chkAll("R6 both 128", 128, 128, 1, 0);
    cmd(0, 0, 0, 0, 0, 1, 0);
    chkAll("R7 rx 127 tx 128 stays passive", 128, 127, 1, 0);
    cmd(0, 0, 1, 0, 0, 0, 0);
    chkAll("R7 both 127 active", 127, 127, 0, 0);
  endtask

  task automatic testRxSaturate();
    doReset();
    for (int i = 0; i < 31; i++) cmd(0, 0, 0, 1, 1, 0, 0);
    chkAll("R3 rx 248", 0, 248, 1, 0);
    cmd(0, 0, 0, 1, 1, 0, 0);
    chk("R3 rx saturate +8", int'(rxErrCount), 255);
    cmd(0, 0, 0, 1, 0, 0, 0);
    chkAll("R3 rx saturate +1", 0, 255, 1, 0);
  endtask

  task automatic testBusOff();
    doReset();
    for (int i = 0; i < 40; i++) cmd(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) cmd(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 31; i++) cmd(1, 1, 0, 0, 0, 0, 0);
    chkAll("R8 tx 248 passive", 248, 5, 1, 0);
    cmd(1, 1, 0, 0, 0, 0, 0);
    chkAll("R8 tx 256 bus-off", 256, 5, 0, 1);
    cmd(1, 1, 0, 1, 1, 0, 0);
    chkAll("R9 incs ignored", 256, 5, 0, 1);
    cmd(0, 0, 1, 0, 0, 1, 0);
    chkAll("R9 decs ignored", 256, 5, 0, 1);
    for (int i = 0; i < 127; i++) cmd(0, 0, 0, 0, 0, 0, 1);
    chkAll("R10 127 idles still bus-off", 256, 5, 0, 1);
    cmd(0, 0, 0, 0, 0, 0, 1);
    chkAll("R10 recovered", 0, 0, 0, 0);
    cmd(1, 0, 0, 0, 0, 0, 0);
    chkAll("R10 counting resumes", 1, 0, 0, 0);
  endtask

  initial begin
    testReset();
    testTxSteps();
    testRxSteps();
    testPassive();
    testRxSaturate();
    testBusOff();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule